// File: doc/BRIEF.md
# Banked Register File Mapper with Index Shadows

This block owns the mapping of the eight working registers onto the bottom of internal RAM. The RAM holds four banks of eight byte registers, and bank *b* occupies addresses 8·b through 8·b+7. Two bank-select bits choose the active bank. The block turns a register number into a RAM address for that bank. It also passes writes through to a simple single-port RAM, either at a direct address or at a register number that it maps itself.

The block keeps a copy of the active bank's register 0 and register 1, so an indirect access gets its pointer without a RAM read. These copies stay coherent with RAM. A write to the active bank's register 0 or 1, by either addressing mode, updates the copy in the same step. When the bank-select bits change, the block spends a fixed four cycles reloading both copies from the new bank. It reads register 0 first and then register 1, and each read returns one clock after its address.

The write port is valid/ready. `wr_ready` is low exactly while `busy` is high. A write is accepted in a cycle where both `wr_valid` and `wr_ready` are high. Until then the source must hold `wr_valid`, `wr_by_reg`, `wr_addr` and `wr_data` unchanged. The bank-change strobe is a plain control pulse and is not queued. The RAM must return read data one clock after `ram_re`, and it must commit a write at the clock edge of `ram_we`.

Top module: `brf_banked_regs`

## Requirements
- R1: `map_addr` equals 8·(active bank) + `rd_reg`, combinationally. The active bank is 0 after reset.
- R2: After reset, `idx_r0` and `idx_r1` are 0x00, `busy` is 0 and `wr_ready` is 1.
- R3: An accepted write with `wr_by_reg`=0 drives `ram_we`=1, `ram_addr`=`wr_addr` and `ram_wdata`=`wr_data` in the same cycle.
- R4: An accepted write with `wr_by_reg`=1 drives `ram_addr` = 8·(active bank) + `wr_addr[2:0]` in the same cycle.
- R5: An accepted write whose RAM address is the active bank's register 0 (address 8·b) or register 1 (address 8·b+1) sets `idx_r0` or `idx_r1` to the written byte in the next cycle.
- R6: A write to any other address, including register 0 or 1 of an inactive bank, leaves both shadows unchanged.
- R7: A strobe on `bank_chg` while idle, with `bank_sel` different from the active bank, raises `busy` in the next cycle for exactly four cycles. `wr_ready` is 0 throughout those cycles.
- R8: When `busy` falls after a reload, `idx_r0` and `idx_r1` hold the RAM contents at 8·b and 8·b+1 of the new bank b. From that cycle on, `map_addr` uses the new bank.
- R9: A `bank_chg` strobe with `bank_sel` equal to the active bank starts no reload, and `busy` stays 0.
- R10: A `bank_chg` strobe while `busy` is high is ignored. The reload in progress still lasts four cycles and the active bank stays as it was.
- R11: The first busy cycle drives `ram_re` at address 8·b. The second busy cycle drives `ram_re` at 8·b+1.
- R12: While `busy` is high, no write is accepted and `ram_we` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_sel | input | 2 | Requested bank-select bits (00 = bank 0 … 11 = bank 3) |
| bank_chg | input | 1 | Strobe: the bank-select bits were written |
| rd_reg | input | 3 | Register number to map |
| map_addr | output | 8 | RAM address of `rd_reg` in the active bank |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write can be accepted (low during reload) |
| wr_by_reg | input | 1 | 1: `wr_addr[2:0]` is a register number; 0: `wr_addr` is a direct address |
| wr_addr | input | 8 | Write address or register number |
| wr_data | input | 8 | Write data |
| ram_addr | output | 8 | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_re | output | 1 | RAM read enable (data returns next cycle) |
| ram_rdata | input | 8 | RAM read data |
| idx_r0 | output | 8 | Shadow of the active bank's register 0 |
| idx_r1 | output | 8 | Shadow of the active bank's register 1 |
| busy | output | 1 | Shadow reload in progress |

## Verification
The bench fills all 32 registers with arithmetic patterns and visits every bank. It checks the mapped address for each register number and the reloaded shadows after each switch. If the bank decode were wrong, every mapped address and reloaded shadow would land on a neighbouring bank. If the read data were taken on the wrong cycle, the two shadows would swap or copy each other. Direct writes to register 0 of the active bank and of an inactive bank tell apart a shadow match that ignores the bank from a correct one. A write held during a reload targets the new bank's register 0, so an accepted write would show up in the reloaded shadow. A strobe that repeats the current bank and one that arrives mid-reload catch a design that reloads needlessly, stretches `busy`, or switches banks out of turn.

// File: rtl/brf_pkg.sv
package brf_pkg;

  // Reload sequencer states. Every non-idle state is one busy cycle.
  typedef enum logic [2:0] {
    RL_IDLE,
    RL_FETCH0,   // address register 0 of the new bank
    RL_FETCH1,   // address register 1, capture register 0 data
    RL_CATCH1,   // capture register 1 data
    RL_TAIL      // fixed padding cycle
  } reload_t;

  localparam int unsigned SHADOWS    = 2;
  localparam int unsigned RELOAD_LEN = 4;

endpackage

// File: rtl/brf_bank_map.sv
// Maps a bank number and a register number onto a RAM address.
module brf_bank_map #(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 2,
  parameter int REG_W  = 3
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [REG_W-1:0]  regn,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD = ADDR_W - BANK_W - REG_W;

  generate
    if (PAD > 0) begin : g_pad
      assign addr = {{PAD{1'b0}}, bank, regn};
    end else begin : g_exact
      assign addr = {bank, regn};
    end
  endgenerate
endmodule

// File: rtl/brf_reload_seq.sv
// Tracks the active bank and runs the fixed four-cycle shadow reload.
module brf_reload_seq
  import brf_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              bank_chg,
  output logic [BANK_W-1:0] act_bank,
  output logic              busy,
  output logic              fetch_en,
  output logic              fetch_idx,
  output logic [SHADOWS-1:0] ld_en
);
  reload_t state, state_nx;
  logic    start;

  assign start = bank_chg && (state == RL_IDLE) && (bank_sel != act_bank);

  always_comb begin
    state_nx = state;
    unique case (state)
      RL_IDLE:   if (start) state_nx = RL_FETCH0;
      RL_FETCH0: state_nx = RL_FETCH1;
      RL_FETCH1: state_nx = RL_CATCH1;
      RL_CATCH1: state_nx = RL_TAIL;
      RL_TAIL:   state_nx = RL_IDLE;
      default:   state_nx = RL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RL_IDLE;
      act_bank <= '0;
    end else begin
      state <= state_nx;
      if (start) act_bank <= bank_sel;
    end
  end

  assign busy      = (state != RL_IDLE);
  assign fetch_en  = (state == RL_FETCH0) || (state == RL_FETCH1);
  assign fetch_idx = (state == RL_FETCH1);
  assign ld_en[0]  = (state == RL_FETCH1);
  assign ld_en[1]  = (state == RL_CATCH1);
endmodule

// File: rtl/brf_shadow_set.sv
// Holds the register-0/1 images of the active bank and keeps them coherent.
module brf_shadow_set
  import brf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int BANK_W = 2,
  parameter int REG_W  = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [BANK_W-1:0]                act_bank,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic [SHADOWS-1:0]               ld_en,
  input  logic [DATA_W-1:0]                ld_data,
  output logic [SHADOWS-1:0][DATA_W-1:0]   sh_q
);
  genvar i;
  generate
    for (i = 0; i < SHADOWS; i++) begin : g_slot
      logic [ADDR_W-1:0] slot_addr;
      logic              hit;

      brf_bank_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W)) u_map (
        .bank (act_bank),
        .regn (REG_W'(i)),
        .addr (slot_addr)
      );

      assign hit = wr_en && (wr_addr == slot_addr);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sh_q[i] <= '0;
        else if (ld_en[i])   sh_q[i] <= ld_data;
        else if (hit)        sh_q[i] <= wr_data;
      end
    end
  endgenerate
endmodule

// File: rtl/brf_banked_regs.sv
module brf_banked_regs
  import brf_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 8,
  parameter int NUM_BANKS     = 4,
  parameter int REGS_PER_BANK = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_sel,
  input  logic                         bank_chg,
  input  logic [$clog2(REGS_PER_BANK)-1:0] rd_reg,
  output logic [ADDR_W-1:0]            map_addr,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic                         wr_by_reg,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [ADDR_W-1:0]            ram_addr,
  output logic                         ram_we,
  output logic [DATA_W-1:0]            ram_wdata,
  output logic                         ram_re,
  input  logic [DATA_W-1:0]            ram_rdata,
  output logic [DATA_W-1:0]            idx_r0,
  output logic [DATA_W-1:0]            idx_r1,
  output logic                         busy
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int REG_W  = $clog2(REGS_PER_BANK);

  logic [BANK_W-1:0]               act_bank;
  logic                            fetch_en;
  logic                            fetch_idx;
  logic [SHADOWS-1:0]              ld_en;
  logic [ADDR_W-1:0]               reg_wr_addr;
  logic [ADDR_W-1:0]               fetch_addr;
  logic [ADDR_W-1:0]               eff_wr_addr;
  logic                            wr_take;
  logic [SHADOWS-1:0][DATA_W-1:0]  sh_q;

  brf_reload_seq #(.BANK_W(BANK_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_sel  (bank_sel),
    .bank_chg  (bank_chg),
    .act_bank  (act_bank),
    .busy      (busy),
    .fetch_en  (fetch_en),
    .fetch_idx (fetch_idx),
    .ld_en     (ld_en)
  );

  // Register number -> address for the lookup output
  brf_bank_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W)) u_map_rd (
    .bank (act_bank),
    .regn (rd_reg),
    .addr (map_addr)
  );

  // Register-number writes
  brf_bank_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W)) u_map_wr (
    .bank (act_bank),
    .regn (wr_addr[REG_W-1:0]),
    .addr (reg_wr_addr)
  );

  // Reload fetches
  brf_bank_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W)) u_map_ld (
    .bank (act_bank),
    .regn (REG_W'(fetch_idx)),
    .addr (fetch_addr)
  );

  assign wr_ready    = !busy;
  assign wr_take     = wr_valid && wr_ready;
  assign eff_wr_addr = wr_by_reg ? reg_wr_addr : wr_addr;

  assign ram_re    = fetch_en;
  assign ram_we    = wr_take;
  assign ram_addr  = fetch_en ? fetch_addr : eff_wr_addr;
  assign ram_wdata = wr_data;

  brf_shadow_set #(
    .DATA_W (DATA_W), .ADDR_W (ADDR_W), .BANK_W (BANK_W), .REG_W (REG_W)
  ) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_bank (act_bank),
    .wr_en    (wr_take),
    .wr_addr  (eff_wr_addr),
    .wr_data  (wr_data),
    .ld_en    (ld_en),
    .ld_data  (ram_rdata),
    .sh_q     (sh_q)
  );

  assign idx_r0 = sh_q[0];
  assign idx_r1 = sh_q[1];
endmodule

// File: rtl/brf_banked_regs_chk.sv
module brf_banked_regs_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int BANK_W = 2,
  parameter int REG_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BANK_W-1:0] bank_sel,
  input logic              bank_chg,
  input logic [BANK_W-1:0] act_bank,
  input logic              busy,
  input logic              ram_we,
  input logic              ram_re,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [DATA_W-1:0] ram_wdata,
  input logic [DATA_W-1:0] idx_r0,
  input logic [DATA_W-1:0] idx_r1
);
  logic [2:0]        run;
  logic [ADDR_W-1:0] base;

  assign base = ADDR_W'(act_bank) << REG_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 3'd1;
    else           run <= '0;
  end

  AST_NO_WRITE_IN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ram_we); // R12
  AST_RELOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_chg && !busy && bank_sel != act_bank) |=> busy); // R7
  AST_SAME_BANK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_chg && !busy && bank_sel == act_bank) |=> !busy); // R9
  AST_RELOAD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < 3'd4); // R7
  AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == 3'd4); // R10
  AST_FETCH_R0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (ram_re && ram_addr == base)); // R11
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ram_we) |=> ($stable(idx_r0) && $stable(idx_r1))); // R6
  AST_SHADOW0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ram_we && ram_addr == base) |=> idx_r0 == $past(ram_wdata)); // R5
  AST_SHADOW1_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ram_we && ram_addr == base + ADDR_W'(1)) |=> idx_r1 == $past(ram_wdata)); // R5
endmodule

bind brf_banked_regs brf_banked_regs_chk #(
  .DATA_W (DATA_W), .ADDR_W (ADDR_W), .BANK_W (BANK_W), .REG_W (REG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bank_sel  (bank_sel),
  .bank_chg  (bank_chg),
  .act_bank  (act_bank),
  .busy      (busy),
  .ram_we    (ram_we),
  .ram_re    (ram_re),
  .ram_addr  (ram_addr),
  .ram_wdata (ram_wdata),
  .idx_r0    (idx_r0),
  .idx_r1    (idx_r1)
);

// File: tb/brf_banked_regs_test.sv
`timescale 1ns/1ps
module brf_banked_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bank_sel = '0;
  logic       bank_chg = 1'b0;
  logic [2:0] rd_reg = '0;
  logic [7:0] map_addr;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic       wr_by_reg = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] ram_addr;
  logic       ram_we;
  logic [7:0] ram_wdata;
  logic       ram_re;
  logic [7:0] ram_rdata;
  logic [7:0] idx_r0;
  logic [7:0] idx_r1;
  logic       busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [32];
  int         tb_bank = 0;
  logic [7:0] exp0 = '0;
  logic [7:0] exp1 = '0;

  always #2 clk = ~clk;

  brf_banked_regs uut (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .bank_chg(bank_chg),
    .rd_reg(rd_reg), .map_addr(map_addr), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_by_reg(wr_by_reg), .wr_addr(wr_addr), .wr_data(wr_data),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_re(ram_re),
    .ram_rdata(ram_rdata), .idx_r0(idx_r0), .idx_r1(idx_r1), .busy(busy)
  );

  // RAM model: one-cycle read, write committed at the edge
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  function automatic logic [7:0] pat(input int b, input int r);
    return 8'((b * 37 + r * 11 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic sweep_map();
    for (int r = 0; r < 8; r++) begin
      rd_reg = 3'(r);
      #1 chk(map_addr == 8'(tb_bank * 8 + r), "R1 map_addr", map_addr, tb_bank * 8 + r);
    end
  endtask

  task automatic wr(input bit byreg, input logic [7:0] a, input logic [7:0] d);
    int phys;
    phys = byreg ? (tb_bank * 8 + int'(a[2:0])) : int'(a);
    @(negedge clk);
    wr_valid = 1'b1; wr_by_reg = byreg; wr_addr = a; wr_data = d;
    #1;
    if (byreg) chk(ram_we && ram_addr == 8'(phys), "R4 reg-mode write addr", ram_addr, phys);
    else chk(ram_we && ram_addr == 8'(phys) && ram_wdata == d, "R3 direct write", ram_addr, phys);
    @(negedge clk);
    wr_valid = 1'b0;
    if (phys < 32) exp_mem[phys] = d;
    if (phys == tb_bank * 8)     exp0 = d;
    if (phys == tb_bank * 8 + 1) exp1 = d;
    #1;
    chk(idx_r0 == exp0, "R5/R6 shadow r0 after write", idx_r0, exp0);
    chk(idx_r1 == exp1, "R5/R6 shadow r1 after write", idx_r1, exp1);
  endtask

  task automatic reload(input int nb, input bit mid, input int alt, input bit offer);
    int n;
    @(negedge clk);
    bank_sel = 2'(nb); bank_chg = 1'b1;
    @(negedge clk);
    bank_chg = 1'b0;
    if (offer) begin
      wr_valid = 1'b1; wr_by_reg = 1'b0; wr_addr = 8'(nb * 8); wr_data = 8'hEE;
    end
    #1;
    chk(busy && ram_re && ram_addr == 8'(nb * 8), "R11 first fetch register 0", ram_addr, nb * 8);
    n = 0;
    while (busy && n < 20) begin
      n++;
      if (n == 2) begin
        chk(ram_re && ram_addr == 8'(nb * 8 + 1), "R11 second fetch register 1", ram_addr, nb * 8 + 1);
        if (mid) begin bank_sel = 2'(alt); bank_chg = 1'b1; end
      end
      if (n == 3) bank_chg = 1'b0;
      chk(!wr_ready, "R7 ready low while busy", wr_ready, 0);
      if (offer) chk(!ram_we, "R12 no write during reload", ram_we, 0);
      @(negedge clk); #1;
    end
    chk(n == 4, mid ? "R10 busy length with mid strobe" : "R7 busy length", n, 4);
    chk(wr_ready, "R7 ready back after reload", wr_ready, 1);
    wr_valid = 1'b0;
    tb_bank = nb;
    exp0 = exp_mem[nb * 8];
    exp1 = exp_mem[nb * 8 + 1];
    chk(idx_r0 == exp0, "R8 reloaded r0", idx_r0, exp0);
    chk(idx_r1 == exp1, "R8 reloaded r1", idx_r1, exp1);
    sweep_map();
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 32; i++) exp_mem[i] = 8'h00;
    ram_rdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(idx_r0 == 8'h00 && idx_r1 == 8'h00, "R2 shadows clear", {idx_r1, idx_r0}, 0);
    chk(!busy && wr_ready, "R2 idle after reset", {busy, wr_ready}, 1);
    sweep_map();

    // Fill every bank through register-number writes
    for (int b = 0; b < 4; b++) begin
      if (b != 0) reload(b, 1'b0, 0, 1'b0);
      for (int r = 0; r < 8; r++) wr(1'b1, 8'(r), pat(b, r));
    end
    // Visit each bank again and confirm the reloaded images
    for (int b = 0; b < 4; b++) begin
      if (b != tb_bank) reload(b, 1'b0, 0, 1'b0);
      chk(idx_r0 == pat(b, 0) && idx_r1 == pat(b, 1), "R8 pattern images", {idx_r1, idx_r0},
          {pat(b, 1), pat(b, 0)});
    end

    // Direct-address writes: active bank is 3
    wr(1'b0, 8'h18, 8'hA5);   // active register 0 (R5)
    wr(1'b0, 8'h19, 8'h5A);   // active register 1 (R5)
    wr(1'b0, 8'h00, 8'h3C);   // inactive bank register 0 (R6)
    wr(1'b0, 8'h09, 8'hC3);   // inactive bank register 1 (R6)
    wr(1'b0, 8'h40, 8'h77);   // outside the register area (R6)
    wr(1'b0, 8'h1A, 8'h11);   // active register 2 (R6)

    // Same-bank strobe: no reload (R9)
    @(negedge clk);
    bank_sel = 2'(tb_bank); bank_chg = 1'b1;
    @(negedge clk);
    bank_chg = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #1 chk(!busy && wr_ready, "R9 no reload on same bank", busy, 0);
      @(negedge clk);
    end

    // Inactive-bank writes become visible after switching to that bank
    reload(0, 1'b0, 0, 1'b0);
    chk(idx_r0 == 8'h3C, "R6 coherent after switch r0", idx_r0, 8'h3C);
    reload(1, 1'b0, 0, 1'b0);
    chk(idx_r1 == 8'hC3, "R6 coherent after switch r1", idx_r1, 8'hC3);

    // Strobe during reload is ignored (R10)
    reload(2, 1'b1, 3, 1'b0);
    chk(map_addr == 8'(16 + int'(rd_reg)), "R10 bank unchanged by mid strobe", map_addr, 16 + int'(rd_reg));

    // Write offered during reload is held off; it targets the new register 0 (R12)
    reload(0, 1'b0, 0, 1'b1);
    chk(idx_r0 == 8'h3C, "R12 held write not taken", idx_r0, 8'h3C);

    // Register-number write after switch updates shadows (R5)
    wr(1'b1, 8'h00, 8'h81);
    wr(1'b1, 8'h01, 8'h42);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule